// File: doc/BRIEF.md
# Triggered Interval Timer with Programmable Time Base

This block measures out intervals as whole multiples of a base period. A clock divider, loaded from a ratio input, produces one tick every base period T. An eight-bit binary counter counts those ticks, and each of its bits is brought out as an output weighted 2^n·T. A rising edge on the trigger input starts a timing cycle. It clears the counter and the divider and sets every output LOW. A rising edge on the reset input ends the cycle, and every output returns HIGH.

A feedback mask picks which counter outputs are ANDed into one combined output. When the mask is nonzero, the combined output going HIGH ends the cycle without outside help. The result is a one-shot whose LOW time is the mask value times T. When the mask is zero, nothing feeds back, and the counter keeps running and wrapping until an outside reset arrives. An active-low pulse output marks each base period while a cycle runs.

Trigger and reset are asynchronous inputs. Each one passes through a two-stage synchroniser and a rising-edge detector, so an edge takes effect three clocks after it is applied.

Top module: `trig_interval_timer`

## Requirements
- R1: After `rst_n` is released, with no trigger or reset edge, `cnt_o` is all ones, `wired_o` is 1 and `tick_n_o` is 1.
- R2: A rising edge on `trig_in` while idle starts a cycle. Three clocks after the edge is applied, `cnt_o` reads all zeros.
- R3: While a cycle runs, `tick_n_o` is 0 for one clock in every `div_ratio` clocks. This happens in the last clock of each period, counted from the first active clock. A `div_ratio` of 0 acts as 1. While idle, `tick_n_o` stays 1.
- R4: The counter advances by one on each tick. Bit n of `cnt_o` is counter bit n, so `j` clocks into a cycle `cnt_o` equals floor(j / ratio) modulo 256.
- R5: A rising edge on `reset_in` ends a running cycle. Three clocks after the edge is applied, `cnt_o` is all ones and ticks stop.
- R6: A trigger edge alone during a running cycle has no effect. Counting continues without a break.
- R7: If a trigger edge arrives in the same clock as an end request, whether that request comes from `reset_in` or from feedback, the trigger wins. The counter restarts from zero and the cycle stays active.
- R8: `wired_o` is 1 exactly when every `cnt_o` bit whose `fb_mask` bit is 1 is also 1. It is 1 when `fb_mask` is zero.
- R9: With `fb_mask` nonzero, the cycle ends one clock after `wired_o` goes HIGH. `wired_o` is LOW for `fb_mask`·ratio clocks from the first active clock, `cnt_o` reads `fb_mask` in the clock where `wired_o` rises, and it reads all ones in the next clock.
- R10: With `fb_mask` zero, the counter wraps from 255 to 0 and keeps counting until a reset edge arrives.
- R11: Only edges act. Holding `trig_in` high through a reset edge leaves the block idle, and a reset edge while idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Trigger request; a rising edge starts a cycle |
| reset_in | input | 1 | End request; a rising edge stops a cycle |
| div_ratio | input | DIV_W | Base period in clocks (0 is taken as 1) |
| fb_mask | input | CNT_W | Selects the outputs ANDed into `wired_o` and fed back |
| cnt_o | output | CNT_W | Counter outputs, bit n weighted 2^n·T; all ones when idle |
| wired_o | output | 1 | AND of the selected counter outputs |
| tick_n_o | output | 1 | Active-low time-base pulse, one clock per period |

## Verification
The checker holds several rules on every clock:
- the outputs are all HIGH whenever the block is idle;
- no tick appears outside a cycle;
- any nonzero change of the count is a single step that follows a tick;
- a one-shot ends in the clock after its combined output rises;
- a simultaneous trigger and end restarts the count from zero;
- a lone trigger leaves a running cycle running.

Some behaviour only the bench scenarios can show, because it depends on exact clock counts across a whole cycle:
- the three-clock latency through the synchronisers;
- the count value at a chosen offset for random ratios;
- the wrap from 255 to 0;
- the exact one-shot length for random masks;
- a trigger landing in the very clock that feedback ends a cycle;
- the level-versus-edge behaviour of the inputs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Action the control state takes in the current clock.
    typedef enum logic [1:0] {
        CTL_HOLD  = 2'd0,
        CTL_START = 2'd1,
        CTL_STOP  = 2'd2,
        CTL_STEP  = 2'd3
    } ctl_act_e;

    // A trigger edge outranks any end request. A trigger alone only acts while idle.
    function automatic ctl_act_e pick_action(
        input logic running,
        input logic trig_edge,
        input logic end_req,
        input logic tick
    );
        if (trig_edge && (!running || end_req)) return CTL_START;
        if (end_req)                            return CTL_STOP;
        if (running && tick)                    return CTL_STEP;
        return CTL_HOLD;
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], din};
        st_d.prev = st_q.sync[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.sync[LAST] & ~st_q.prev;

endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
    } tb_t;

    tb_t              st_d, st_q;
    logic [DIV_W-1:0] eff_ratio;
    logic             at_end;

    always_comb begin
        eff_ratio = (ratio == '0) ? DIV_W'(1) : ratio;
        at_end    = (st_q.div >= eff_ratio - DIV_W'(1));
        tick      = run & at_end;
        st_d      = st_q;
        if (clear || !run || at_end) st_d.div = '0;
        else                         st_d.div = st_q.div + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tmr_wired_and.sv
module tmr_wired_and #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits,
    input  logic [W-1:0] sel,
    output logic         all_high
);
    logic [W-1:0] term;

    for (genvar i = 0; i < W; i++) begin : g_term
        assign term[i] = bits[i] | ~sel[i];
    end

    assign all_high = &term;

endmodule

// File: rtl/trig_interval_timer.sv
module trig_interval_timer #(
    parameter int CNT_W       = 8,
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic             reset_in,
    input  logic [DIV_W-1:0] div_ratio,
    input  logic [CNT_W-1:0] fb_mask,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wired_o,
    output logic             tick_n_o
);
    import tmr_pkg::*;

    localparam logic [CNT_W-1:0] IDLE_CNT = '1;

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t     st_d, st_q;
    ctl_act_e act;
    logic     trig_rise, rst_rise, tb_tick, wired, fb_end, end_req;

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk(clk), .rst_n(rst_n), .din(trig_in), .rise(trig_rise)
    );

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk(clk), .rst_n(rst_n), .din(reset_in), .rise(rst_rise)
    );

    tmr_timebase #(.DIV_W(DIV_W)) u_tbase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.active),
        .clear ((act == CTL_START) || (act == CTL_STOP)),
        .ratio (div_ratio),
        .tick  (tb_tick)
    );

    tmr_wired_and #(.W(CNT_W)) u_wand (
        .bits(st_q.cnt), .sel(fb_mask), .all_high(wired)
    );

    always_comb begin
        fb_end  = st_q.active & (|fb_mask) & wired;
        end_req = rst_rise | fb_end;
        act     = pick_action(st_q.active, trig_rise, end_req, tb_tick);
        st_d    = st_q;
        case (act)
            CTL_START: begin
                st_d.active = 1'b1;
                st_d.cnt    = '0;
            end
            CTL_STOP: begin
                st_d.active = 1'b0;
                st_d.cnt    = IDLE_CNT;
            end
            CTL_STEP: st_d.cnt = st_q.cnt + CNT_W'(1);
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active <= 1'b0;
            st_q.cnt    <= IDLE_CNT;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o    = st_q.cnt;
    assign wired_o  = wired;
    assign tick_n_o = ~tb_tick;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             active,
    input logic             trig_rise,
    input logic             rst_rise,
    input logic [CNT_W-1:0] fb_mask,
    input logic [CNT_W-1:0] cnt_o,
    input logic             wired_o,
    input logic             tick_n_o
);
    AST_IDLE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (cnt_o == '1 && wired_o)); // R1

    AST_NO_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_n_o |-> active); // R3

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && cnt_o != $past(cnt_o) && cnt_o != '0)
        |-> ($past(!tick_n_o) && cnt_o == $past(cnt_o) + CNT_W'(1))); // R4

    AST_RETRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (active && trig_rise && !rst_rise && !((|fb_mask) && wired_o))
        |=> (active && (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + CNT_W'(1)))); // R6

    AST_TRIG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_rise && rst_rise) |=> (active && cnt_o == '0)); // R7

    AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (|fb_mask) && wired_o && !trig_rise) |=> !active); // R9

    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> cnt_o == '0); // R2

endmodule

bind trig_interval_timer tmr_checker #(.CNT_W(CNT_W)) u_tmr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (st_q.active),
    .trig_rise (trig_rise),
    .rst_rise  (rst_rise),
    .fb_mask   (fb_mask),
    .cnt_o     (cnt_o),
    .wired_o   (wired_o),
    .tick_n_o  (tick_n_o)
);

// File: tb/trig_interval_timer_bench.sv
module trig_interval_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_in = 1'b0;
    logic        reset_in = 1'b0;
    logic [15:0] div_ratio = 16'd1;
    logic [7:0]  fb_mask = 8'd0;
    logic [7:0]  cnt_o;
    logic        wired_o;
    logic        tick_n_o;

    int vec = 0;
    int miss = 0;
    bit done = 1'b0;
    int j;
    int r;
    int m;

    always #2 clk = ~clk;

    trig_interval_timer u_trig_interval_timer (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .reset_in(reset_in),
        .div_ratio(div_ratio), .fb_mask(fb_mask),
        .cnt_o(cnt_o), .wired_o(wired_o), .tick_n_o(tick_n_o)
    );

    function automatic int exp_cnt(int jj, int rr);
        return (jj / rr) % 256;
    endfunction

    function automatic int exp_tick_n(int jj, int rr);
        return ((jj % rr) == rr - 1) ? 0 : 1;
    endfunction

    function automatic int exp_wired(int c, int msk);
        return ((c & msk) == msk) ? 1 : 0;
    endfunction

    task automatic check(string req, int act, int exp);
        vec++;
        if (act != exp) begin
            miss++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic fire_trig();
        trig_in = 1'b1;
        cyc(3);
        trig_in = 1'b0;
    endtask

    task automatic fire_reset();
        reset_in = 1'b1;
        cyc(3);
        reset_in = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        vec++;
        miss++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_up();
    end

    initial begin
        void'($urandom(32'd7119));
        @(negedge clk);
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
        // R1 reset state
        check("R1 cnt", cnt_o, 255);
        check("R1 wired", wired_o, 1);
        check("R1 tick", tick_n_o, 1);

        // R11 reset edge while idle changes nothing
        fire_reset();
        cyc(2);
        check("R11 idle reset", cnt_o, 255);

        // R2, R4, R10: free run at ratio 1 with wrap
        div_ratio = 16'd1;
        fb_mask = 8'd0;
        fire_trig();
        check("R2 start zero", cnt_o, 0);
        cyc(255);
        check("R4 count 255", cnt_o, 255);
        cyc(1);
        check("R10 wrap", cnt_o, 0);
        cyc(5);
        check("R10 after wrap", cnt_o, 5);
        fire_reset();
        check("R5 stopped", cnt_o, 255);
        for (int k = 0; k < 6; k++) begin
            cyc(1);
            check("R3 idle tick", tick_n_o, 1);
        end

        // R3 ratio 0 acts as 1
        div_ratio = 16'd0;
        fire_trig();
        cyc(10);
        check("R3 ratio zero", cnt_o, 10);
        fire_reset();
        check("R5 stop", cnt_o, 255);

        // R3, R4, R8: random free runs
        for (int it = 0; it < 8; it++) begin
            r = $urandom_range(1, 7);
            div_ratio = 16'(r);
            fb_mask = 8'd0;
            fire_trig();
            j = 0;
            for (int p = 0; p < 6; p++) begin
                int d;
                d = $urandom_range(1, 40);
                cyc(d);
                j += d;
                check("R4 count", cnt_o, exp_cnt(j, r));
                check("R3 tick", tick_n_o, exp_tick_n(j, r));
                check("R8 empty mask", wired_o, 1);
            end
            fire_reset();
            check("R5 end", cnt_o, 255);
        end

        // R6: a trigger alone during a cycle is ignored
        div_ratio = 16'd3;
        fire_trig();
        cyc(20);
        fire_trig();
        j = 23;
        check("R6 retrigger", cnt_o, exp_cnt(j, 3));
        cyc(10);
        j += 10;
        check("R6 continue", cnt_o, exp_cnt(j, 3));
        fire_reset();

        // R7: trigger and reset together restart the count
        div_ratio = 16'd2;
        fire_trig();
        cyc(20);
        trig_in = 1'b1;
        reset_in = 1'b1;
        cyc(3);
        trig_in = 1'b0;
        reset_in = 1'b0;
        check("R7 restart", cnt_o, 0);
        cyc(4);
        check("R7 counting", cnt_o, 2);
        fire_reset();

        // R8, R9: random one-shots
        for (int it = 0; it < 6; it++) begin
            int j1;
            r = $urandom_range(1, 4);
            m = $urandom_range(1, 255);
            div_ratio = 16'(r);
            fb_mask = 8'(m);
            fire_trig();
            j1 = $urandom_range(0, m * r - 1);
            cyc(j1);
            check("R8 wired low", wired_o, exp_wired(exp_cnt(j1, r), m));
            check("R9 mid count", cnt_o, exp_cnt(j1, r));
            cyc(m * r - 1 - j1);
            check("R9 last low", wired_o, 0);
            check("R9 last count", cnt_o, m - 1);
            cyc(1);
            check("R9 wired high", wired_o, 1);
            check("R9 count at end", cnt_o, m);
            cyc(1);
            check("R9 self end", cnt_o, 255);
        end

        // R7: trigger meets feedback end in the same clock
        div_ratio = 16'd2;
        fb_mask = 8'd3;
        fire_trig();
        cyc(4);
        trig_in = 1'b1;
        cyc(3);
        trig_in = 1'b0;
        check("R7 feedback restart", cnt_o, 0);
        cyc(7);
        check("R9 second shot", cnt_o, 255);

        // R11: a held trigger level does not restart after reset
        fb_mask = 8'd0;
        div_ratio = 16'd1;
        trig_in = 1'b1;
        cyc(3);
        check("R11 start", cnt_o, 0);
        fire_reset();
        cyc(10);
        check("R11 held level", cnt_o, 255);
        trig_in = 1'b0;
        cyc(2);

        finish_up();
    end
endmodule